// File: doc/BRIEF.md
# Dual-Select Static Word Memory with Output Gating

This block is a clocked model of a 1024-bit static memory that holds 256 words of 4 bits each. An 8-bit address picks the word. Two select inputs of opposite polarity must both be true before the block responds. An active-low write strobe chooses between storing and fetching. An active-low output enable gates the read data. The three-state output is modelled as a 4-bit data bus plus a drive-enable bit. The bus reads as zero whenever the drive enable is low.

The storage is arranged as 32 rows of 32 bits. The five low address bits choose a row. The three high address bits steer a column selector that takes one 4-bit word out of that row. A write is level-sensitive: on every rising clock edge where the block is selected and the write strobe is low, the addressed word takes the current input data. A read is combinational from the current address, so a word stored on one edge can be read in the cycle after. The storage is not cleared by reset. While reset is high, the outputs do not drive and nothing is stored.

Top module: `sram_dualsel`

## Requirements
- R1: The block stores 256 independent 4-bit words, addressed by the 8-bit `addr`; a word written to one address reads back unchanged after all other addresses have been written.
- R2: When `sel_n` is 1 or `sel_p` is 0, `dout_en` is 0 and no word is stored, whatever `wr_n`, `oe_n`, `addr` and `din` are.
- R3: When `sel_n` is 0, `sel_p` is 1, `wr_n` is 1 and `oe_n` is 0, `dout_en` is 1 and `dout` equals the word stored at `addr`, uninverted, in the same cycle.
- R4: When `sel_n` is 0, `sel_p` is 1 and `wr_n` is 0, `din` is stored at `addr` on the rising clock edge and `dout_en` is 0, for either value of `oe_n`.
- R5: When `oe_n` is 1, `dout_en` is 0 whatever the select and write inputs are.
- R6: A write held over several edges stores `din` on each edge, so the last value presented wins; it is readable in the cycle after the final write edge.
- R7: Whenever `dout_en` is 0, `dout` is 4'h0.
- R8: `addr[4:0]` picks the row and `addr[7:5]` picks the 4-bit column within the 32-bit row; a write to one column leaves the other seven words of that row unchanged.
- R9: While `rst` is 1, `dout_en` is 0 and no word is stored; stored contents are neither cleared nor changed by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes occur on its rising edge |
| rst | input | 1 | Synchronous active-high reset; blocks writes and output drive |
| addr | input | 8 | Word address; low 5 bits pick the row, high 3 bits pick the column |
| din | input | 4 | Write data |
| sel_n | input | 1 | Select, active low |
| sel_p | input | 1 | Select, active high |
| wr_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| dout | output | 4 | Read data, zero when not driving |
| dout_en | output | 1 | Output drive enable; 0 stands for high impedance |

## Verification
A wrong decode of the select, write and enable inputs shows in `dout_en` in the same cycle as the offending input pattern, because the control path holds no state. A cell that took a wrong value, or a write that landed when it should have been blocked, stays hidden until that address is read. The bench therefore reads back every address after filling the array, and re-reads after each blocked write. A column decode fault corrupts a neighbouring word in the same row. That fault is caught by reading all eight columns of the row right after a single-column write.

// File: rtl/sram_dualsel_pkg.sv
package sram_dualsel_pkg;

  // Access mode decoded from the control inputs in one cycle.
  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,  // not selected, or held in reset
    MODE_READ   = 2'd1,  // selected, reading, outputs driven
    MODE_WRITE  = 2'd2,  // selected, storing, outputs floated
    MODE_HIDDEN = 2'd3   // selected, reading, outputs gated off
  } acc_mode_e;

  function automatic logic mode_drives(acc_mode_e m);
    return m == MODE_READ;
  endfunction

  function automatic logic mode_stores(acc_mode_e m);
    return m == MODE_WRITE;
  endfunction

endpackage

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_dualsel_pkg::*;
(
  input  logic      rst,
  input  logic      sel_n,
  input  logic      sel_p,
  input  logic      wr_n,
  input  logic      oe_n,
  output acc_mode_e mode,
  output logic      store,
  output logic      drive
);

  logic chosen;

  assign chosen = !sel_n && sel_p && !rst;

  always_comb begin
    if (!chosen) begin
      mode = MODE_IDLE;
    end else if (!wr_n) begin
      mode = MODE_WRITE;
    end else if (!oe_n) begin
      mode = MODE_READ;
    end else begin
      mode = MODE_HIDDEN;
    end
  end

  assign store = mode_stores(mode);
  assign drive = mode_drives(mode);

endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int ROW_BITS = 5,
  parameter int COL_BITS = 3,
  parameter int DATA_W   = 4,
  localparam int ROWS    = 1 << ROW_BITS,
  localparam int COLS    = 1 << COL_BITS,
  localparam int ROW_W   = DATA_W * COLS
) (
  input  logic                clk,
  input  logic                we,
  input  logic [ROW_BITS-1:0] row,
  input  logic [COL_BITS-1:0] col,
  input  logic [DATA_W-1:0]   wdata,
  output logic [ROW_W-1:0]    rrow
);

  logic [ROW_W-1:0] cells [ROWS];
  logic [COLS-1:0]  col_hit;

  // One-hot column strobe, one lane per word in the row.
  for (genvar c = 0; c < COLS; c++) begin : g_hit
    assign col_hit[c] = (col == COL_BITS'(c));
  end

  // Lane-masked row write; no reset so the array maps onto RAM cells.
  always_ff @(posedge clk) begin
    if (we) begin
      for (int c = 0; c < COLS; c++) begin
        if (col_hit[c]) begin
          cells[row][c*DATA_W +: DATA_W] <= wdata;
        end
      end
    end
  end

  assign rrow = cells[row];

endmodule

// File: rtl/sram_colsel.sv
module sram_colsel #(
  parameter int COL_BITS = 3,
  parameter int DATA_W   = 4,
  localparam int COLS    = 1 << COL_BITS,
  localparam int ROW_W   = DATA_W * COLS
) (
  input  logic [ROW_W-1:0]    rrow,
  input  logic [COL_BITS-1:0] col,
  output logic [DATA_W-1:0]   word
);

  logic [DATA_W-1:0] lanes [COLS];

  for (genvar c = 0; c < COLS; c++) begin : g_lane
    assign lanes[c] = rrow[c*DATA_W +: DATA_W];
  end

  assign word = lanes[col];

endmodule

// File: rtl/sram_dualsel.sv
module sram_dualsel #(
  parameter int ROW_BITS = 5,
  parameter int COL_BITS = 3,
  parameter int DATA_W   = 4,
  localparam int ADDR_W  = ROW_BITS + COL_BITS,
  localparam int ROW_W   = DATA_W << COL_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              sel_n,
  input  logic              sel_p,
  input  logic              wr_n,
  input  logic              oe_n,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);

  import sram_dualsel_pkg::*;

  acc_mode_e             mode;
  logic                  store;
  logic                  drive;
  logic [ROW_BITS-1:0]   row;
  logic [COL_BITS-1:0]   col;
  logic [ROW_W-1:0]      rrow;
  logic [DATA_W-1:0]     word;

  // Low bits choose the row, high bits steer the column selector.
  assign row = addr[ROW_BITS-1:0];
  assign col = addr[ADDR_W-1:ROW_BITS];

  sram_ctrl u_ctrl (
    .rst   (rst),
    .sel_n (sel_n),
    .sel_p (sel_p),
    .wr_n  (wr_n),
    .oe_n  (oe_n),
    .mode  (mode),
    .store (store),
    .drive (drive)
  );

  sram_array #(
    .ROW_BITS (ROW_BITS),
    .COL_BITS (COL_BITS),
    .DATA_W   (DATA_W)
  ) u_array (
    .clk   (clk),
    .we    (store),
    .row   (row),
    .col   (col),
    .wdata (din),
    .rrow  (rrow)
  );

  sram_colsel #(
    .COL_BITS (COL_BITS),
    .DATA_W   (DATA_W)
  ) u_colsel (
    .rrow (rrow),
    .col  (col),
    .word (word)
  );

  assign dout_en = drive && (mode != MODE_IDLE);
  assign dout    = dout_en ? word : '0;

endmodule

// File: rtl/sram_dualsel_chk.sv
module sram_dualsel_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] din,
  input logic              sel_n,
  input logic              sel_p,
  input logic              wr_n,
  input logic              oe_n,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en
);

  AST_DESEL_FLOAT: assert property (@(posedge clk) disable iff (rst)
    (sel_n || !sel_p) |-> !dout_en); // R2

  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && sel_p && wr_n && !oe_n) |-> dout_en); // R3

  AST_WRITE_FLOAT: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && sel_p && !wr_n) |-> !dout_en); // R4

  AST_OE_GATES: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !dout_en); // R5

  AST_WRITE_THEN_READ: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!sel_n && sel_p && !wr_n) &&
     !sel_n && sel_p && wr_n && !oe_n && addr == $past(addr))
    |-> dout == $past(din)); // R6

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !dout_en |-> dout == '0); // R7

  always_comb begin
    if (rst) begin
      AST_RESET_FLOAT: assert (!dout_en); // R9
    end
  end

endmodule

bind sram_dualsel sram_dualsel_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .addr    (addr),
  .din     (din),
  .sel_n   (sel_n),
  .sel_p   (sel_p),
  .wr_n    (wr_n),
  .oe_n    (oe_n),
  .dout    (dout),
  .dout_en (dout_en)
);

// File: tb/sram_dualsel_bench.sv
module sram_dualsel_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] addr = '0;
  logic [3:0] din = '0;
  logic       sel_n = 1'b1;
  logic       sel_p = 1'b0;
  logic       wr_n = 1'b1;
  logic       oe_n = 1'b1;
  logic [3:0] dout;
  logic       dout_en;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic       en;
    logic [3:0] data;
    string      tag;
  } exp_t;

  exp_t       sb_q[$];
  logic [3:0] ref_mem [256];
  event       mon_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_dualsel u_sram_dualsel (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .din     (din),
    .sel_n   (sel_n),
    .sel_p   (sel_p),
    .wr_n    (wr_n),
    .oe_n    (oe_n),
    .dout    (dout),
    .dout_en (dout_en)
  );

  // Driver: apply one cycle of inputs, push the expected output, update model.
  task automatic step(input logic r, input logic sn, input logic sp,
                      input logic wn, input logic on, input logic [7:0] a,
                      input logic [3:0] d, input string tag);
    exp_t e;
    logic chosen;
    @(negedge clk);
    rst = r; sel_n = sn; sel_p = sp; wr_n = wn; oe_n = on; addr = a; din = d;
    chosen = !r && !sn && sp;
    e.tag  = tag;
    e.en   = chosen && wn && !on;
    e.data = e.en ? ref_mem[a] : 4'h0;
    sb_q.push_back(e);
    if (chosen && !wn) ref_mem[a] = d;
    #1;
    ->mon_ev;
  endtask

  // Monitor: compare the live outputs against the queued expectation.
  initial begin
    forever begin
      exp_t e;
      @(mon_ev);
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard empty en=%0b dout=%h expected none", dout_en, dout);
      end else begin
        e = sb_q.pop_front();
        if (dout_en !== e.en || dout !== e.data) begin
          errors++;
          $display("FAIL %s en=%0b dout=%h expected en=%0b dout=%h",
                   e.tag, dout_en, dout, e.en, e.data);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired got running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [3:0] pat(input int a, input int k);
    return 4'((a * 7 + k * 5 + 3) & 15);
  endfunction

  initial begin
    // R9: reset state with write and read requested
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h10, 4'hA, "R9 reset floats");
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h10, 4'h0, "R9 reset read floats");
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h10, 4'h6, "R4 write floats oe low");
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h10, 4'hF, "R9 reset blocks write");
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h10, 4'h0, "R9 contents kept");

    // R1 / R4: fill every address, oe_n alternating
    for (int a = 0; a < 256; a++)
      step(1'b0, 1'b0, 1'b1, 1'b0, 1'(a & 1), 8'(a), pat(a, 0), "R4 write floats");
    // R1 / R3 / R8: read everything back
    for (int a = 0; a < 256; a++)
      step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'(a), 4'h0, "R1 R3 readback");

    // R8: single column write, check the whole row (row 5, column 1)
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h25, ~pat(8'h25, 0), "R8 column write");
    for (int c = 0; c < 8; c++)
      step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'(c * 32 + 5), 4'h0, "R8 row neighbours");

    // R2: deselected by each select, write and read both requested
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h42, ~pat(8'h42, 0), "R2 sel_n high");
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h42, ~pat(8'h42, 0), "R2 sel_p low");
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h42, 4'h0, "R2 both off read");
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h42, 4'h0, "R2 no write landed");

    // R5: output enable high in each mode
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h42, 4'h0, "R5 read gated");
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'h42, 4'h0, "R5 deselected gated");
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h43, 4'h9, "R5 R4 write gated");
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h43, 4'h0, "R4 write with oe high");

    // R6: level write held over three edges, last value wins
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hC7, 4'h1, "R6 hold 1");
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hC7, 4'h2, "R6 hold 2");
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hC7, 4'hE, "R6 hold 3");
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'hC7, 4'h0, "R6 last value");

    // R7 / R1: second pattern pass with reads interleaved
    for (int a = 0; a < 256; a += 17) begin
      step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'(a), pat(a, 3), "R7 write zero bus");
      step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'(a), 4'h0, "R1 rewrite read");
    end
    for (int a = 0; a < 256; a++)
      step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'(a), 4'h0, "R1 final readback");

    @(negedge clk);
    #2;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule